// File: doc/BRIEF.md
# ZQ Calibration Request Scheduler

This block sits between a user-facing maintenance port and the command path of a DRAM memory controller. It decides when a ZQ calibration command goes to the PHY-side command port. It keeps at most one calibration request outstanding. Before it presents the command, it waits until every data transaction already in flight has completed.

The block has two modes. When `INTERVAL` is non-zero, a built-in interval counter raises calibration requests by itself. When `INTERVAL` is zero, automatic maintenance is disabled and only a single-cycle pulse on `usr_req` starts a calibration. Once a request is accepted, `data_hold` rises to stop the controller from accepting new data requests, so the drain is certain to finish. The command is then offered with `zq_valid` until `zq_ready` is seen. A user-originated request is answered by a one-cycle `usr_ack` in the handshake cycle.

Top module: `zqcal_sched`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `usr_ack`, `zq_valid` and `data_hold` are all low.
- R2: A request accepted in an idle cycle raises `data_hold` from the next cycle. `data_hold` stays high until the cycle after the command handshake.
- R3: `zq_valid` rises only in the cycle after a cycle in which `data_hold` was high and `busy_cnt` was zero. It then stays high until the cycle in which `zq_ready` is high.
- R4: `usr_ack` is high for exactly the one cycle in which `zq_valid` and `zq_ready` are both high, and only if the outstanding request came from `usr_req`.
- R5: A `usr_req` pulse that arrives while a request is outstanding (that is, while `data_hold` is high) is ignored. It yields no second command and no second `usr_ack`.
- R6: With `INTERVAL` = 0, `zq_valid` never rises unless `usr_req` has been pulsed.
- R7: With `INTERVAL` = N > 0, and with `busy_cnt` at zero and `zq_ready` held high, successive automatic commands are handshaken exactly N+2 cycles apart. Any ZQ handshake reloads the interval counter.
- R8: A command that the interval counter raised completes without any `usr_ack` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| usr_req | input | 1 | Single-cycle user calibration request |
| usr_ack | output | 1 | Single-cycle acknowledge of a user request, in the handshake cycle |
| busy_cnt | input | CNT_W | Number of data transactions still pending in the controller |
| data_hold | output | 1 | High while a calibration is outstanding; blocks new data requests |
| zq_valid | output | 1 | ZQ command offered to the PHY-side command port |
| zq_ready | input | 1 | Command port accepts the ZQ command |

## Verification
The hardest situation to reach is a second user pulse that lands while the first request is still outstanding. It must arrive both during the drain and during the wait on `zq_ready`. The stimulus table holds `busy_cnt` non-zero and then withholds `zq_ready` for several cycles, so that extra pulses fall into each of those windows. The bench then confirms that exactly one acknowledge appears. In periodic mode, the exact spacing between automatic commands is measured by counting cycles between handshakes once the drain is empty.

// File: rtl/zqcal_pkg.sv
package zqcal_pkg;
   typedef enum logic [1:0] {
      ZS_IDLE  = 2'd0,
      ZS_DRAIN = 2'd1,
      ZS_ISSUE = 2'd2
   } zq_state_t;
endpackage

// File: rtl/zqcal_timer.sv
module zqcal_timer #(
   parameter int INTERVAL = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   output logic due
);
   generate
      if (INTERVAL < 0) begin : g_bad_interval
         $error("zqcal_timer: INTERVAL must not be negative");
      end
      if (INTERVAL == 0) begin : g_user_only
         assign due = 1'b0;
      end else begin : g_periodic
         localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
         localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);
         logic [TW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (reload) begin
               cnt_q <= '0;
            end else if (cnt_q != LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign due = (cnt_q == LAST);

         // R7: the counter never exceeds its last value
         p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate
endmodule

// File: rtl/zqcal_ctrl.sv
module zqcal_ctrl
   import zqcal_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             usr_req,
   input  logic             tick,
   input  logic [CNT_W-1:0] busy_cnt,
   input  logic             zq_ready,
   output logic             data_hold,
   output logic             zq_valid,
   output logic             usr_ack,
   output logic             fire
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("zqcal_ctrl: CNT_W must be at least 1");
      end
   endgenerate

   zq_state_t st_q;
   logic      from_user_q;
   logic      drained;

   assign drained = (busy_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ZS_IDLE;
         from_user_q <= 1'b0;
      end else begin
         unique case (st_q)
            ZS_IDLE: begin
               if (usr_req || tick) begin
                  st_q        <= ZS_DRAIN;
                  from_user_q <= usr_req;
               end
            end
            ZS_DRAIN: begin
               if (drained) st_q <= ZS_ISSUE;
            end
            ZS_ISSUE: begin
               if (zq_ready) begin
                  st_q        <= ZS_IDLE;
                  from_user_q <= 1'b0;
               end
            end
            default: st_q <= ZS_IDLE;
         endcase
      end
   end

   assign data_hold = (st_q != ZS_IDLE);
   assign zq_valid  = (st_q == ZS_ISSUE);
   assign fire      = zq_valid && zq_ready;
   assign usr_ack   = fire && from_user_q;

   // R2: the command is never offered without data being held off
   p_hold_covers_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      zq_valid |-> data_hold);
   // R3: the command appears only after an empty drain
   p_valid_after_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zq_valid) |-> $past(busy_cnt == '0));
   // R3: the command stays offered until accepted
   p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (zq_valid && !zq_ready) |=> zq_valid);
   // R4: the acknowledge is one cycle and only on a handshake
   p_ack_on_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      usr_ack |-> (zq_valid && zq_ready));
   p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      usr_ack |=> !usr_ack);
endmodule

// File: rtl/zqcal_sched.sv
module zqcal_sched #(
   parameter int INTERVAL = 0,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             usr_req,
   output logic             usr_ack,
   input  logic [CNT_W-1:0] busy_cnt,
   output logic             data_hold,
   output logic             zq_valid,
   input  logic             zq_ready
);
   logic tick;
   logic fire;

   zqcal_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (fire),
      .due    (tick)
   );

   zqcal_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .usr_req   (usr_req),
      .tick      (tick),
      .busy_cnt  (busy_cnt),
      .zq_ready  (zq_ready),
      .data_hold (data_hold),
      .zq_valid  (zq_valid),
      .usr_ack   (usr_ack),
      .fire      (fire)
   );
endmodule

// File: tb/sim_zqcal_sched.sv
module sim_zqcal_sched;
   localparam int PERIOD = 10;
   localparam int CW     = 4;
   localparam int N1     = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   // u0: user-only mode
   logic          req0 = 1'b0, rdy0 = 1'b0;
   logic [CW-1:0] busy0 = '0;
   logic          ack0, hold0, val0;
   // u1: periodic mode
   logic          req1 = 1'b0, rdy1 = 1'b1;
   logic [CW-1:0] busy1 = '0;
   logic          ack1, hold1, val1;

   zqcal_sched #(.INTERVAL(0), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .usr_req(req0), .usr_ack(ack0),
      .busy_cnt(busy0), .data_hold(hold0), .zq_valid(val0), .zq_ready(rdy0));
   zqcal_sched #(.INTERVAL(N1), .CNT_W(CW)) u1 (
      .clk(clk), .rst_n(rst_n), .usr_req(req1), .usr_ack(ack1),
      .busy_cnt(busy1), .data_hold(hold1), .zq_valid(val1), .zq_ready(rdy1));

   int checks = 0;
   int errors = 0;

   task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s {hold,valid,ack} actual %b expected %b", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic          req;
      logic [CW-1:0] busy;
      logic          rdy;
      logic [2:0]    exp; // {data_hold, zq_valid, usr_ack}
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 4'd0, 1'b0, 3'b000}, // R2 idle
      '{1'b1, 4'd2, 1'b0, 3'b000}, // R2 request sampled at edge
      '{1'b0, 4'd2, 1'b1, 3'b100}, // R3 draining, busy
      '{1'b1, 4'd1, 1'b1, 3'b100}, // R5 pulse during drain ignored
      '{1'b0, 4'd0, 1'b0, 3'b100}, // R3 drain empty
      '{1'b0, 4'd0, 1'b0, 3'b110}, // R3 offered, not ready
      '{1'b1, 4'd0, 1'b0, 3'b110}, // R5 pulse while offered ignored
      '{1'b0, 4'd0, 1'b1, 3'b111}, // R4 handshake with ack
      '{1'b0, 4'd0, 1'b1, 3'b000}, // R5 no second command
      '{1'b0, 4'd0, 1'b1, 3'b000}, // R5 no second ack
      '{1'b1, 4'd0, 1'b1, 3'b000}, // R2 new request
      '{1'b0, 4'd0, 1'b1, 3'b100}, // R3 one-cycle drain
      '{1'b0, 4'd0, 1'b1, 3'b111}, // R4 immediate handshake
      '{1'b0, 4'd0, 1'b1, 3'b000}  // R2 hold released
   };

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hs_a, hs_b, cyc, seen_ack1, bad_val;
      // R1: during reset
      #(PERIOD * 2 + 1);
      check("R1 in reset u0", {hold0, val0, ack0}, 3'b000);
      check("R1 in reset u1", {hold1, val1, ack1}, 3'b000);
      busy1 = 4'd3;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 check("R1 after reset u0", {hold0, val0, ack0}, 3'b000);

      // table walk on u0
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         req0 = VEC[i].req; busy0 = VEC[i].busy; rdy0 = VEC[i].rdy;
         #1 check($sformatf("R2-5 row %0d", i), {hold0, val0, ack0}, VEC[i].exp);
      end
      req0 = 1'b0;

      // R6: user-only mode stays quiet without requests
      bad_val = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         #1 if (val0 || hold0) bad_val++;
      end
      check("R6 no self-started command", {2'b00, bad_val != 0}, 3'b000);

      // R3/R7: u1 held by pending data, must not offer the command
      bad_val = 0;
      for (int i = 0; i < 3 * N1; i++) begin
         @(negedge clk);
         #1 if (val1) bad_val++;
      end
      check("R3 no command while busy", {2'b00, bad_val != 0}, 3'b000);
      check("R7 periodic request raised hold", {hold1, val1, 1'b0}, 3'b100);

      // R7/R8: measure spacing of automatic handshakes
      busy1 = '0;
      hs_a = -1; hs_b = -1; seen_ack1 = 0; cyc = 0;
      while (hs_b < 0 && cyc < 10 * N1) begin
         @(negedge clk);
         #1;
         if (ack1) seen_ack1++;
         if (val1 && rdy1) begin
            if (hs_a < 0) hs_a = cyc; else hs_b = cyc;
         end
         cyc++;
      end
      checks++;
      if (hs_b - hs_a != N1 + 2 || hs_a < 0) begin
         errors++;
         $display("FAIL R7 spacing actual %0d expected %0d", hs_b - hs_a, N1 + 2);
      end
      check("R8 no ack for periodic", {2'b00, seen_ack1 != 0}, 3'b000);

      // R4: user request on periodic instance right after a handshake
      @(negedge clk);
      req1 = 1'b1;
      @(negedge clk);
      req1 = 1'b0;
      #1 check("R4 u1 draining", {hold1, val1, ack1}, 3'b100);
      @(negedge clk);
      #1 check("R4 u1 user ack", {hold1, val1, ack1}, 3'b111);

      // R1: reset in mid-operation
      @(negedge clk);
      req0 = 1'b1; busy0 = 4'd5;
      @(negedge clk);
      req0 = 1'b0;
      #1 check("R2 hold before reset", {hold0, val0, ack0}, 3'b100);
      rst_n = 1'b0;
      #1 check("R1 reset clears", {hold0, val0, ack0}, 3'b000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule